// File: doc/BRIEF.md
# Impulse-Radio Packet Receive Sequencer

This block is the control state machine of an impulse-radio packet receiver. It sits between a host, which says when the upper layer can take a packet, and the signal-processing blocks (energy correlator, timing acquisition, template builder and bit demodulator). It steps through the receive phases in order. First it waits for the host. Then it detects energy on the channel, qualifies the acquisition result against a lock threshold and asks for the demodulation template. It then hunts for the start-of-frame byte 0x55 in the demodulated bit stream, reads the length byte and hands out that many payload bytes. Last it pulses packet-done and goes back to idle.

While it hunts for the delimiter, the block also watches the correlation strength. When that strength drops under a separate threshold, the signal has ended, which is the case when the receiver locked onto the tail of a foreign packet. The block then drops the hunt and goes back to energy detection, so it cannot hang. A frame on air looks like `FF FF FF FF 55 LEN payload...`, sent MSB first.

States and their 4-bit codes on `state_o`: IDLE=0, ENERGY=1, ACQ_WAIT=2, ACQ_CHECK=3, TMPL=4, SEARCH=5, LEN=6, PAYLOAD=7, DONE=8. The transitions are: IDLE→ENERGY on start; ENERGY→ACQ_WAIT on energy; ACQ_WAIT→ACQ_CHECK on acquisition done; ACQ_CHECK→TMPL on lock, or ACQ_CHECK→ENERGY on no lock; TMPL→SEARCH on template done; SEARCH→LEN on delimiter match, or SEARCH→ENERGY on fade; LEN→PAYLOAD on a non-zero length, or LEN→DONE on zero; PAYLOAD→DONE on the last byte; DONE→IDLE always.

Top module: `irx_pkt_seq`

## Requirements
- R1: After reset the state is IDLE (code 0) with `pkt_done_o`, `byte_vld_o` and `tmpl_req_o` low. The state stays IDLE until `start_i` is sampled high, and then moves to ENERGY (code 1).
- R2: In ENERGY the block moves to ACQ_WAIT (code 2) on the cycle after `energy_i` is strictly greater (unsigned) than `thr_energy_i`. A metric equal to or below the threshold keeps it in ENERGY.
- R3: ACQ_WAIT moves to ACQ_CHECK (code 3) on `acq_done_i`. In ACQ_CHECK the first `corr_vld_i` decides the next state: `corr_i` strictly greater than `thr_lock_i` leads to TMPL (code 4), and any other value leads back to ENERGY.
- R4: `tmpl_req_o` is high exactly while the state is TMPL. `tmpl_done_i` moves the block to SEARCH (code 5), and SEARCH is entered from no other state.
- R5: In SEARCH each valid bit is shifted in MSB first. The delimiter is checked on every bit, at any alignment: when the latest 8 bits equal 0x55, the block moves to LEN (code 6).
- R6: The 8 bits after the delimiter form the length byte, which `len_o` holds. A non-zero length leads to PAYLOAD (code 7).
- R7: In PAYLOAD exactly `len_o` bytes are assembled MSB first on 8-bit boundaries. Each byte is shown on `byte_o` with a one-cycle `byte_vld_o`. After the last byte the block enters DONE (code 8).
- R8: `pkt_done_o` is a one-cycle pulse, high only in DONE. The state after DONE is IDLE.
- R9: A length byte of 0 moves from LEN straight to DONE, and no `byte_vld_o` is raised.
- R10: In SEARCH, a `corr_vld_i` with `corr_i` strictly below `thr_drop_i` moves the block to ENERGY. This fade exit wins over a delimiter match in the same cycle. Bits that arrive while the block is in ENERGY are ignored and do not move it out of ENERGY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Host strobe: upper layer ready to receive |
| thr_energy_i | input | EN_W | Energy detection threshold |
| thr_lock_i | input | CORR_W | Acquisition lock threshold |
| thr_drop_i | input | CORR_W | Signal-fade threshold used during delimiter search |
| energy_i | input | EN_W | Self-correlation energy metric |
| acq_done_i | input | 1 | Timing acquisition finished strobe |
| corr_i | input | CORR_W | Absolute correlation value |
| corr_vld_i | input | 1 | Strobe for `corr_i` |
| tmpl_done_i | input | 1 | Template generation finished strobe |
| bit_i | input | 1 | Demodulated bit |
| bit_vld_i | input | 1 | Strobe for `bit_i` |
| state_o | output | 4 | Current state code |
| tmpl_req_o | output | 1 | Template generation request |
| byte_o | output | 8 | Payload byte |
| byte_vld_o | output | 1 | Strobe for `byte_o` |
| len_o | output | 8 | Captured payload length |
| pkt_done_o | output | 1 | Packet-ready pulse |

## Verification
The bench drives the reference stream FF FF FF FF 55 03 01 02 03 and a longer packet of five bytes. These show that the delimiter is found, the length is read and the bytes are counted correctly, and that payload bytes equal to 0x55 are not taken for a delimiter. A stream where the delimiter starts three bits off the byte boundary shows that the match is made on every bit and not only on byte edges. A packet with zero length separates the direct path to DONE from the payload path. Two more patterns cover the decision points: a fade in the middle of the search, followed by a delimiter sent while the block is in ENERGY, and a correlation value that fails acquisition. Threshold values equal to the limit probe the strict comparisons.

// File: rtl/irx_seq_pkg.sv
package irx_seq_pkg;
    typedef enum logic [3:0] {
        ST_IDLE      = 4'd0,
        ST_ENERGY    = 4'd1,
        ST_ACQ_WAIT  = 4'd2,
        ST_ACQ_CHECK = 4'd3,
        ST_TMPL      = 4'd4,
        ST_SEARCH    = 4'd5,
        ST_LEN       = 4'd6,
        ST_PAYLOAD   = 4'd7,
        ST_DONE      = 4'd8
    } rx_state_e;

    localparam logic [7:0] FRAME_DELIM = 8'h55;
endpackage

// File: rtl/irx_bit_deframer.sv
module irx_bit_deframer
    import irx_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       search_i,
    input  logic       bytes_i,
    input  logic       bit_i,
    input  logic       bit_vld_i,
    output logic       delim_hit_o,
    output logic       byte_done_o,
    output logic [7:0] byte_w_o
);
    logic [6:0] shreg_q;
    logic [2:0] bitcnt_q;

    assign byte_w_o    = {shreg_q, bit_i};
    assign delim_hit_o = search_i && bit_vld_i && (byte_w_o == FRAME_DELIM);
    assign byte_done_o = bytes_i && bit_vld_i && (bitcnt_q == 3'd7);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q  <= 7'h7F;
            bitcnt_q <= 3'd0;
        end else if (clr_i) begin
            shreg_q  <= 7'h7F;
            bitcnt_q <= 3'd0;
        end else if (bit_vld_i && (search_i || bytes_i)) begin
            shreg_q <= byte_w_o[6:0];
            if (bytes_i) bitcnt_q <= bitcnt_q + 3'd1;
        end
    end

    AST_CNT_IDLE_IN_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
        search_i |-> bitcnt_q == 3'd0);  // R5
endmodule

// File: rtl/irx_payload_ctr.sv
module irx_payload_ctr
    import irx_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  rx_state_e  state_i,
    input  logic       byte_done_i,
    input  logic [7:0] byte_w_i,
    output logic       last_o,
    output logic [7:0] len_o,
    output logic [7:0] byte_o,
    output logic       byte_vld_o
);
    logic [7:0] remain_q;

    assign last_o = (remain_q == 8'd1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q   <= 8'd0;
            len_o      <= 8'd0;
            byte_o     <= 8'd0;
            byte_vld_o <= 1'b0;
        end else begin
            byte_vld_o <= 1'b0;
            if (byte_done_i) begin
                if (state_i == ST_LEN) begin
                    len_o    <= byte_w_i;
                    remain_q <= byte_w_i;
                end else if (state_i == ST_PAYLOAD) begin
                    byte_o     <= byte_w_i;
                    byte_vld_o <= 1'b1;
                    remain_q   <= remain_q - 8'd1;
                end
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        state_i == ST_PAYLOAD |-> remain_q != 8'd0);  // R7
    AST_BYTE_FROM_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |-> $past(state_i) == ST_PAYLOAD);  // R9
endmodule

// File: rtl/irx_seq_fsm.sv
module irx_seq_fsm
    import irx_seq_pkg::*;
#(
    parameter int EN_W   = 16,
    parameter int CORR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [EN_W-1:0]   thr_energy_i,
    input  logic [CORR_W-1:0] thr_lock_i,
    input  logic [CORR_W-1:0] thr_drop_i,
    input  logic [EN_W-1:0]   energy_i,
    input  logic              acq_done_i,
    input  logic [CORR_W-1:0] corr_i,
    input  logic              corr_vld_i,
    input  logic              tmpl_done_i,
    input  logic              delim_hit_i,
    input  logic              byte_done_i,
    input  logic [7:0]        byte_w_i,
    input  logic              last_i,
    output rx_state_e         state_o,
    output logic              tmpl_req_o,
    output logic              pkt_done_o
);
    rx_state_e state_q, state_d;
    logic      fade;

    assign fade = corr_vld_i && (corr_i < thr_drop_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_i) state_d = ST_ENERGY;
            ST_ENERGY:    if (energy_i > thr_energy_i) state_d = ST_ACQ_WAIT;
            ST_ACQ_WAIT:  if (acq_done_i) state_d = ST_ACQ_CHECK;
            ST_ACQ_CHECK: if (corr_vld_i)
                              state_d = (corr_i > thr_lock_i) ? ST_TMPL : ST_ENERGY;
            ST_TMPL:      if (tmpl_done_i) state_d = ST_SEARCH;
            ST_SEARCH:    if (fade) state_d = ST_ENERGY;
                          else if (delim_hit_i) state_d = ST_LEN;
            ST_LEN:       if (byte_done_i)
                              state_d = (byte_w_i == 8'd0) ? ST_DONE : ST_PAYLOAD;
            ST_PAYLOAD:   if (byte_done_i && last_i) state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_o    = state_q;
        tmpl_req_o = (state_q == ST_TMPL);
        pkt_done_o = (state_q == ST_DONE);
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start_i) |=> state_q == ST_IDLE);  // R1
    AST_SEARCH_AFTER_TMPL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEARCH && $past(state_q) != ST_SEARCH) |-> $past(state_q) == ST_TMPL);  // R4
    AST_FADE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEARCH && corr_vld_i && corr_i < thr_drop_i) |=> state_q == ST_ENERGY);  // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done_o |=> !pkt_done_o && state_q == ST_IDLE);  // R8
endmodule

// File: rtl/irx_pkt_seq.sv
module irx_pkt_seq
    import irx_seq_pkg::*;
#(
    parameter int EN_W   = 16,
    parameter int CORR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [EN_W-1:0]   thr_energy_i,
    input  logic [CORR_W-1:0] thr_lock_i,
    input  logic [CORR_W-1:0] thr_drop_i,
    input  logic [EN_W-1:0]   energy_i,
    input  logic              acq_done_i,
    input  logic [CORR_W-1:0] corr_i,
    input  logic              corr_vld_i,
    input  logic              tmpl_done_i,
    input  logic              bit_i,
    input  logic              bit_vld_i,
    output logic [3:0]        state_o,
    output logic              tmpl_req_o,
    output logic [7:0]        byte_o,
    output logic              byte_vld_o,
    output logic [7:0]        len_o,
    output logic              pkt_done_o
);
    rx_state_e  st;
    logic       delim_hit, byte_done, last;
    logic [7:0] byte_w;
    logic       in_search, in_bytes, clr;

    assign state_o   = st;
    assign in_search = (st == ST_SEARCH);
    assign in_bytes  = (st == ST_LEN) || (st == ST_PAYLOAD);
    assign clr       = (st == ST_TMPL);

    irx_seq_fsm #(.EN_W(EN_W), .CORR_W(CORR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .thr_energy_i(thr_energy_i), .thr_lock_i(thr_lock_i), .thr_drop_i(thr_drop_i),
        .energy_i(energy_i), .acq_done_i(acq_done_i), .corr_i(corr_i),
        .corr_vld_i(corr_vld_i), .tmpl_done_i(tmpl_done_i),
        .delim_hit_i(delim_hit), .byte_done_i(byte_done), .byte_w_i(byte_w),
        .last_i(last), .state_o(st), .tmpl_req_o(tmpl_req_o), .pkt_done_o(pkt_done_o)
    );

    irx_bit_deframer u_deframe (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .search_i(in_search),
        .bytes_i(in_bytes), .bit_i(bit_i), .bit_vld_i(bit_vld_i),
        .delim_hit_o(delim_hit), .byte_done_o(byte_done), .byte_w_o(byte_w)
    );

    irx_payload_ctr u_ctr (
        .clk(clk), .rst_n(rst_n), .state_i(st), .byte_done_i(byte_done),
        .byte_w_i(byte_w), .last_o(last), .len_o(len_o), .byte_o(byte_o),
        .byte_vld_o(byte_vld_o)
    );
endmodule

// File: tb/irx_pkt_seq_tb.sv
module irx_pkt_seq_tb_top;
    logic clk = 0, rst_n = 0;
    logic start_i = 0, acq_done_i = 0, corr_vld_i = 0, tmpl_done_i = 0;
    logic bit_i = 0, bit_vld_i = 0;
    logic [15:0] thr_energy_i = 16'd100, thr_lock_i = 16'd500, thr_drop_i = 16'd50;
    logic [15:0] energy_i = 0, corr_i = 0;
    logic [3:0] state_o;
    logic tmpl_req_o, byte_vld_o, pkt_done_o;
    logic [7:0] byte_o, len_o;

    int checks = 0, fails = 0;
    logic [7:0] expq[$];
    bit finished = 0;

    always #4 clk = ~clk;

    irx_pkt_seq dut_i (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(); @(negedge clk); endtask

    // monitor: scoreboard compare on every emitted byte
    always @(negedge clk) if (rst_n && byte_vld_o) begin
        if (expq.size() == 0) chk(0, "R7 unexpected byte", byte_o, 0);
        else begin
            logic [7:0] e;
            e = expq.pop_front();
            chk(byte_o == e, "R7 payload byte", byte_o, e);
        end
    end

    task automatic front();
        start_i = 1; step(); start_i = 0;
        chk(state_o == 4'd1, "R1 start->ENERGY", state_o, 1);
        energy_i = 16'd100; step();
        chk(state_o == 4'd1, "R2 equal energy stays", state_o, 1);
        energy_i = 16'd101; step(); energy_i = 0;
        chk(state_o == 4'd2, "R2 ACQ_WAIT", state_o, 2);
        acq_done_i = 1; step(); acq_done_i = 0;
        chk(state_o == 4'd3, "R3 ACQ_CHECK", state_o, 3);
        corr_i = 16'd900; corr_vld_i = 1; step(); corr_vld_i = 0;
        chk(state_o == 4'd4, "R3 lock->TMPL", state_o, 4);
        chk(tmpl_req_o == 1, "R4 tmpl_req", tmpl_req_o, 1);
        tmpl_done_i = 1; step(); tmpl_done_i = 0;
        chk(state_o == 4'd5 && !tmpl_req_o, "R4 SEARCH", state_o, 5);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            bit_i = b[i]; bit_vld_i = 1; step();
        end
        bit_vld_i = 0;
    endtask

    task automatic send_pkt(input int extra_ones, input logic [7:0] pl[]);
        for (int i = 0; i < 4; i++) send_byte(8'hFF);
        for (int i = 0; i < extra_ones; i++) begin bit_i = 1; bit_vld_i = 1; step(); end
        bit_vld_i = 0;
        send_byte(8'h55);
        chk(state_o == 4'd6, "R5 delimiter->LEN", state_o, 6);
        send_byte(8'(pl.size()));
        chk(len_o == 8'(pl.size()), "R6 length", len_o, pl.size());
        if (pl.size() == 0) begin
            chk(state_o == 4'd8, "R9 zero len->DONE", state_o, 8);
        end else begin
            chk(state_o == 4'd7, "R6 PAYLOAD", state_o, 7);
            foreach (pl[k]) begin expq.push_back(pl[k]); send_byte(pl[k]); end
            chk(state_o == 4'd8, "R7 DONE after last", state_o, 8);
        end
        chk(pkt_done_o == 1, "R8 pkt_done", pkt_done_o, 1);
        step();
        chk(pkt_done_o == 0 && state_o == 4'd0, "R8 back to IDLE", state_o, 0);
        chk(expq.size() == 0, "R7 all bytes seen", expq.size(), 0);
        chk(byte_vld_o == 0, "R9 no stray byte", byte_vld_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        step(); step(); rst_n = 1; step();
        chk(state_o == 0 && !pkt_done_o && !byte_vld_o && !tmpl_req_o, "R1 reset", state_o, 0);
        step(); step();
        chk(state_o == 0, "R1 idle holds", state_o, 0);

        front(); send_pkt(0, '{8'h01, 8'h02, 8'h03});
        front(); send_pkt(3, '{8'h55, 8'hA7, 8'h00, 8'hFF, 8'h55});
        front(); send_pkt(0, '{});

        // R10 fade in search, then bits ignored in ENERGY
        front(); send_byte(8'hFF);
        corr_i = 16'd49; corr_vld_i = 1; step(); corr_vld_i = 0;
        chk(state_o == 4'd1, "R10 fade->ENERGY", state_o, 1);
        send_byte(8'h55); send_byte(8'h02);
        chk(state_o == 4'd1 && !byte_vld_o, "R10 bits ignored in ENERGY", state_o, 1);

        // R3 acquisition failure (corr equal to lock threshold)
        energy_i = 16'd200; step(); energy_i = 0;
        acq_done_i = 1; step(); acq_done_i = 0;
        corr_i = 16'd500; corr_vld_i = 1; step(); corr_vld_i = 0;
        chk(state_o == 4'd1, "R3 no lock->ENERGY", state_o, 1);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule